// File: doc/BRIEF.md
# Rotate Mask Generate Insert Unit

This is a purely combinational 32-bit datapath unit for an integer core. It provides three bit-manipulation operations. The first builds a contiguous mask that may wrap around, from a start index and an end index. The second rotates a source word left and inserts the rotated bits into a target word under a mask. The third merges two words under a mask that arrives as a data operand. Bit indices are big-endian: index 0 is the most significant bit of a word.

The issuing stage supplies the opcode, the source, target and operand words, the two 5-bit mask index fields from the instruction, a record flag and the current summary-overflow bit. The unit returns the result word in the same cycle. When the record flag is set, it also returns a 4-bit condition field that the core writes into its first condition slot.

Top module: `rmgiUnit`

## Requirements
- R1: Base mask for rotate-insert, with b = mbField and e = meField. If b <= e, the set bits are big-endian indices b through e. If b > e, the set bits are indices b through 31 and indices 0 through e. Big-endian index i is vector bit 31-i.
- R2: With opSel = 2'd1, resultWord = (rotl(srcWord, operWord[4:0]) AND mask) OR (tgtWord AND NOT mask), using the R1 mask. operWord[31:5] has no effect.
- R3: A rotate amount of zero passes srcWord unrotated. With mbField = 0 and meField = 31, resultWord equals srcWord.
- R4: With opSel = 2'd0, the start is s = srcWord[4:0] and the end is e = operWord[4:0]. When s <= e, resultWord has big-endian indices s through e set and all other bits clear.
- R5: For the mask-generate operation, when s == e+1, resultWord is all ones.
- R6: For the mask-generate operation, when s > e+1, resultWord is the inverse of the contiguous mask covering indices e+1 through s-1.
- R7: With opSel = 2'd2, resultWord = (srcWord AND operWord) OR (tgtWord AND NOT operWord).
- R8: opSel = 2'd3 is a no-op. resultWord equals tgtWord and crWrite stays 0 regardless of recordEn.
- R9: With recordEn = 1 and a valid opcode, crWrite = 1 and crField = {LT, GT, EQ, SO} in bits 3 to 0. LT, GT and EQ come from a signed compare of resultWord with zero, and SO copies soIn. Otherwise crWrite = 0 and crField = 0.
- R10: tgtWord has no effect on the mask-generate result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 2 | Operation: 0 mask generate, 1 rotate-insert, 2 masked merge, 3 no-op |
| recordEn | input | 1 | Request a condition field update |
| soIn | input | 1 | Current summary-overflow bit |
| srcWord | input | 32 | Source word (mask start in low 5 bits for mask generate) |
| tgtWord | input | 32 | Old target word |
| operWord | input | 32 | Rotate amount, mask end, or merge mask |
| mbField | input | 5 | Mask begin index from the instruction |
| meField | input | 5 | Mask end index from the instruction |
| resultWord | output | 32 | Result word |
| crWrite | output | 1 | Condition field is valid this cycle |
| crField | output | 4 | {LT, GT, EQ, SO} |

## Verification
The assertions hold on every evaluation for a few structural facts:
- the decoded strobes are one-hot;
- the all-ones case of mask generate;
- merged bits follow the source wherever the operand mask is set;
- the identity rotate-insert passes the source through;
- a written condition field has exactly one compare flag and a faithful SO copy.

Only the bench's scenarios can show the remaining behaviour:
- the exact placement of contiguous and wrapped masks;
- rotation by every amount;
- the inverted-mask branch;
- the insensitivity to the target word and to the high operand bits.

The bench sweeps all 1024 index pairs against an arithmetic model for each of these.

// File: rtl/rmgiPkg.sv
package rmgiPkg;
  typedef enum logic [1:0] {
    OP_MASK_GEN = 2'd0,
    OP_ROT_INS  = 2'd1,
    OP_MERGE    = 2'd2,
    OP_NOP      = 2'd3
  } rmgiOp_e;

  typedef struct packed {
    logic doMaskGen;
    logic doRotIns;
    logic doMerge;
    logic crWrite;
  } rmgiStrobes_t;
endpackage

// File: rtl/rmgiCtrl.sv
module rmgiCtrl
  import rmgiPkg::*;
(
  input  logic [1:0]   opSel,
  input  logic         recordEn,
  output rmgiStrobes_t strobes
);
  rmgiOp_e op;

  always_comb begin
    op = rmgiOp_e'(opSel);
    strobes = '0;
    unique case (op)
      OP_MASK_GEN: strobes.doMaskGen = 1'b1;
      OP_ROT_INS:  strobes.doRotIns  = 1'b1;
      OP_MERGE:    strobes.doMerge   = 1'b1;
      default:     ;
    endcase
    // R9 / R8: a record request is honoured only for a real operation
    strobes.crWrite = recordEn && (op != OP_NOP);
  end

  always_comb begin
    a_r8_onehot_strobe: assert ($onehot0({strobes.doMaskGen, strobes.doRotIns, strobes.doMerge}))
      else $error("a_r8_onehot_strobe");
    if (opSel == 2'd3) begin
      a_r8_nop_no_cr: assert (!strobes.crWrite) else $error("a_r8_nop_no_cr");
    end
  end
endmodule

// File: rtl/rmgiDatapath.sv
module rmgiDatapath
  import rmgiPkg::*;
#(
  parameter int W = 32
) (
  input  rmgiStrobes_t          strobes,
  input  logic                  soIn,
  input  logic [W-1:0]          srcWord,
  input  logic [W-1:0]          tgtWord,
  input  logic [W-1:0]          operWord,
  input  logic [$clog2(W)-1:0]  mbField,
  input  logic [$clog2(W)-1:0]  meField,
  output logic [W-1:0]          resultWord,
  output logic [3:0]            crField
);
  localparam int IDX_W = $clog2(W);
  localparam logic [W-1:0]     ALL_ONES = {W{1'b1}};
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(W - 1);

  // Big-endian index mask; wraps when begin exceeds end.
  function automatic logic [W-1:0] baseMask(input logic [IDX_W-1:0] b, input logic [IDX_W-1:0] e);
    logic [W-1:0] fromBegin, toEnd;
    fromBegin = ALL_ONES >> b;
    toEnd     = ALL_ONES << (TOP_IDX - e);
    return (b <= e) ? (fromBegin & toEnd) : (fromBegin | toEnd);
  endfunction

  // Mask generate
  logic [IDX_W-1:0] startIdx, endIdx;
  logic [IDX_W:0]   endPlusOne;
  logic [W-1:0]     genMask;

  always_comb begin
    startIdx   = srcWord[IDX_W-1:0];
    endIdx     = operWord[IDX_W-1:0];
    endPlusOne = {1'b0, endIdx} + 1'b1;
    if ({1'b0, startIdx} < endPlusOne)
      genMask = baseMask(startIdx, endIdx);
    else if ({1'b0, startIdx} == endPlusOne)
      genMask = ALL_ONES;
    else
      genMask = ~baseMask(endIdx + 1'b1, startIdx - 1'b1);
  end

  // Rotate-insert: double-width shift never forms a full-width shift of one word
  logic [IDX_W-1:0] rotAmt;
  logic [2*W-1:0]   doubled;
  logic [W-1:0]     rotated, insMask, insWord;

  always_comb begin
    rotAmt  = operWord[IDX_W-1:0];
    doubled = {srcWord, srcWord} << rotAmt;
    rotated = doubled[2*W-1:W];
    insMask = baseMask(mbField, meField);
    insWord = (rotated & insMask) | (tgtWord & ~insMask);
  end

  // Merge under operand mask
  logic [W-1:0] mergeWord;
  assign mergeWord = (srcWord & operWord) | (tgtWord & ~operWord);

  // Result select
  always_comb begin
    if (strobes.doMaskGen)     resultWord = genMask;
    else if (strobes.doRotIns) resultWord = insWord;
    else if (strobes.doMerge)  resultWord = mergeWord;
    else                       resultWord = tgtWord;
  end

  // Condition field {LT, GT, EQ, SO}
  logic isNeg, isZero;
  always_comb begin
    isNeg  = resultWord[W-1];
    isZero = (resultWord == '0);
    crField = strobes.crWrite ? {isNeg, !isNeg && !isZero, isZero, soIn} : 4'b0;
  end

  always_comb begin
    if (strobes.doMaskGen && ({1'b0, srcWord[IDX_W-1:0]} == {1'b0, operWord[IDX_W-1:0]} + 1'b1)) begin
      a_r5_all_ones: assert (resultWord == ALL_ONES) else $error("a_r5_all_ones");
    end
    if (strobes.doMerge) begin
      a_r7_merge_src: assert (((resultWord ^ srcWord) & operWord) == '0) else $error("a_r7_merge_src");
    end
    if (strobes.doRotIns && operWord[IDX_W-1:0] == '0 && mbField == '0 && meField == TOP_IDX) begin
      a_r3_zero_rotate: assert (resultWord == srcWord) else $error("a_r3_zero_rotate");
    end
    if (strobes.crWrite) begin
      a_r9_cr_onehot: assert ($onehot(crField[3:1]) && crField[0] == soIn) else $error("a_r9_cr_onehot");
    end else begin
      a_r9_cr_quiet: assert (crField == 4'b0) else $error("a_r9_cr_quiet");
    end
  end
endmodule

// File: rtl/rmgiUnit.sv
module rmgiUnit
  import rmgiPkg::*;
(
  input  logic [1:0]  opSel,
  input  logic        recordEn,
  input  logic        soIn,
  input  logic [31:0] srcWord,
  input  logic [31:0] tgtWord,
  input  logic [31:0] operWord,
  input  logic [4:0]  mbField,
  input  logic [4:0]  meField,
  output logic [31:0] resultWord,
  output logic        crWrite,
  output logic [3:0]  crField
);
  rmgiStrobes_t strobes;

  rmgiCtrl i_ctrl (
    .opSel   (opSel),
    .recordEn(recordEn),
    .strobes (strobes)
  );

  rmgiDatapath #(.W(32)) i_dp (
    .strobes   (strobes),
    .soIn      (soIn),
    .srcWord   (srcWord),
    .tgtWord   (tgtWord),
    .operWord  (operWord),
    .mbField   (mbField),
    .meField   (meField),
    .resultWord(resultWord),
    .crField   (crField)
  );

  assign crWrite = strobes.crWrite;
endmodule

// File: tb/test_rmgiUnit.sv
module test_rmgiUnit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  opSel;
  logic        recordEn, soIn;
  logic [31:0] srcWord, tgtWord, operWord;
  logic [4:0]  mbField, meField;
  logic [31:0] resultWord;
  logic        crWrite;
  logic [3:0]  crField;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  rmgiUnit i_rmgiUnit (
    .opSel(opSel), .recordEn(recordEn), .soIn(soIn),
    .srcWord(srcWord), .tgtWord(tgtWord), .operWord(operWord),
    .mbField(mbField), .meField(meField),
    .resultWord(resultWord), .crWrite(crWrite), .crField(crField)
  );

  // Reference model helpers (big-endian index i is vector bit 31-i)
  function automatic logic [31:0] refRange(int lo, int hi);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) r[31-i] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] refBase(int b, int e);
    if (b <= e) return refRange(b, e);
    return refRange(b, 31) | refRange(0, e);
  endfunction

  function automatic logic [31:0] refRotl(logic [31:0] x, int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[(i + n) % 32] = x[i];
    return r;
  endfunction

  function automatic logic [31:0] refMaskGen(int s, int e);
    if (s <= e) return refRange(s, e);
    if (s == e + 1) return 32'hFFFF_FFFF;
    return ~refRange(e + 1, s - 1);
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic checkCr(string tag, logic actW, logic [3:0] actF, logic expW, logic [3:0] expF);
    compared++;
    if (actW !== expW || actF !== expF) begin
      mismatched++;
      $display("FAIL %s: actual w=%0b f=%04b expected w=%0b f=%04b", tag, actW, actF, expW, expF);
    end
  endtask

  function automatic logic [3:0] refCr(logic [31:0] r, logic so);
    logic lt, gt, eq;
    lt = $signed(r) < 0;
    gt = $signed(r) > 0;
    eq = (r == 0);
    return {lt, gt, eq, so};
  endfunction

  task automatic apply(logic [1:0] op, logic rec, logic so, logic [31:0] s, logic [31:0] t,
                       logic [31:0] o, logic [4:0] mb, logic [4:0] me);
    @(posedge clk);
    opSel = op; recordEn = rec; soIn = so; srcWord = s; tgtWord = t;
    operWord = o; mbField = mb; meField = me;
    @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, t, o, exp;
    opSel = 2'd0; recordEn = 0; soIn = 0; srcWord = '0; tgtWord = '0;
    operWord = '0; mbField = '0; meField = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset-state inputs: mask generate of index 0..0
    check32("R4 reset-state mask", resultWord, 32'h8000_0000);
    checkCr("R9 reset-state no record", crWrite, crField, 1'b0, 4'b0);

    // Mask generate sweep
    for (int si = 0; si < 32; si++) begin
      for (int ei = 0; ei < 32; ei++) begin
        s = ($urandom() & 32'hFFFF_FFE0) | si;
        o = ($urandom() & 32'hFFFF_FFE0) | ei;
        t = $urandom();
        apply(2'd0, 1'b0, 1'b0, s, t, o, 5'($urandom()), 5'($urandom()));
        exp = refMaskGen(si, ei);
        if (si <= ei)          check32("R4 mask generate contiguous", resultWord, exp);
        else if (si == ei + 1) check32("R5 mask generate all ones", resultWord, exp);
        else                   check32("R6 mask generate inverted", resultWord, exp);
        // R10: same indices, different target
        apply(2'd0, 1'b0, 1'b0, s, ~t, o, 5'd0, 5'd0);
        check32("R10 target ignored by mask generate", resultWord, exp);
      end
    end

    // Rotate-insert sweep over all begin/end pairs
    for (int b = 0; b < 32; b++) begin
      for (int e = 0; e < 32; e++) begin
        int sh;
        logic rec, so;
        logic [31:0] m;
        sh = int'($urandom() % 32);
        s = $urandom(); t = $urandom();
        o = ($urandom() & 32'hFFFF_FFE0) | sh;
        rec = 1'($urandom()); so = 1'($urandom());
        apply(2'd1, rec, so, s, t, o, 5'(b), 5'(e));
        m = refBase(b, e);
        exp = (refRotl(s, sh) & m) | (t & ~m);
        if (b <= e) check32("R1 R2 rotate-insert contiguous", resultWord, exp);
        else        check32("R1 R2 rotate-insert wrapped", resultWord, exp);
        checkCr("R9 record on rotate-insert", crWrite, crField, rec, rec ? refCr(exp, so) : 4'b0);
      end
    end

    // R3: zero rotate passes source, full mask
    for (int k = 0; k < 8; k++) begin
      s = $urandom();
      apply(2'd1, 1'b0, 1'b0, s, $urandom(), 32'hFFFF_FFE0 & $urandom(), 5'd0, 5'd31);
      check32("R3 zero rotate identity", resultWord, s);
    end

    // R7: merge
    for (int k = 0; k < 256; k++) begin
      s = $urandom(); t = $urandom(); o = $urandom();
      apply(2'd2, 1'b1, 1'b0, s, t, o, 5'($urandom()), 5'($urandom()));
      exp = (s & o) | (t & ~o);
      check32("R7 masked merge", resultWord, exp);
      checkCr("R9 record on merge", crWrite, crField, 1'b1, refCr(exp, 1'b0));
    end

    // R9 corner values: zero, negative, positive
    apply(2'd2, 1'b1, 1'b1, 32'h0, 32'h0, 32'h0, 5'd0, 5'd0);
    checkCr("R9 EQ with SO", crWrite, crField, 1'b1, 4'b0011);
    apply(2'd2, 1'b1, 1'b0, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    checkCr("R9 LT", crWrite, crField, 1'b1, 4'b1000);
    apply(2'd2, 1'b1, 1'b0, 32'h0000_0001, 32'h0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    checkCr("R9 GT", crWrite, crField, 1'b1, 4'b0100);

    // R8: no-op
    for (int k = 0; k < 16; k++) begin
      t = $urandom();
      apply(2'd3, 1'b1, 1'b1, $urandom(), t, $urandom(), 5'($urandom()), 5'($urandom()));
      check32("R8 no-op passes target", resultWord, t);
      checkCr("R8 no-op no record", crWrite, crField, 1'b0, 4'b0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule